// File: doc/BRIEF.md
# RC Time-Constant Measurement Counter

This block estimates the time constant of an external electrode load before stimulation starts. A start request closes the step-excitation switch. While that switch is closed, the load node charges through a fixed resistance. An external comparator reports whether the node is still below a reference threshold. The block counts reference clock cycles for as long as the synchronized comparator level reads "below". When the level reads "above" for one sampled cycle, the block opens the switch and freezes the count into a 3-bit code.

The count scales with the RC product divided by the clock period. A heavier load therefore yields a larger code. The frozen code drives a binary-weighted current DAC outside the block: bit 2 selects the largest programmable current, bit 1 the middle one and bit 0 the smallest. The DAC output is the sum of the currents whose bits are set. The step source, the comparator and the DAC are all analog parts outside this block.

Top module: `rc_tau_meter`

## Requirements
- R1: While reset is asserted and after it is released, `excite_en_o`, `done_o` and `ovf_o` are 0 and `code_o` is 000.
- R2: When idle or done, a start request sampled at a rising edge raises `excite_en_o` and clears `done_o` at that same edge.
- R3: The comparator input passes through a two-stage synchronizer. If the raw input is high at the start edge and at the next H-1 edges (H edges in all), and low from then on, the measured count is H+1.
- R4: The first cycle in which the synchronized level reads "above" ends the measurement. At the start edge plus H+2 edges, `excite_en_o` falls and `done_o` rises.
- R5: Larger loads give larger codes. Raw-high lengths of 0, 2, 4 and 6 cycles yield codes 001, 011, 101 and 111.
- R6: The count saturates at 111 and does not wrap. `ovf_o` is 1 after a measurement in which an increment was attempted at 111, which happens when H is 7 or more. Otherwise `ovf_o` is 0.
- R7: `code_o` and `ovf_o` change only at the edge that ends a measurement. During a measurement they keep the previous result.
- R8: `done_o` stays 1, and the result stays unchanged, until the next accepted start request.
- R9: A start request while a measurement is running is ignored. The running measurement keeps its count and its end time.
- R10: `code_o[2]` carries weight 4, `code_o[1]` weight 2 and `code_o[0]` weight 1. They map to DAC bits b2, b1 and b0.
- R11: `excite_en_o` is 1 only while a measurement is running. It is never 1 together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the count advances once per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Request to begin a measurement |
| cmp_below_i | input | 1 | Raw comparator level, 1 = node below threshold |
| excite_en_o | output | 1 | Closes the step-excitation switch during measurement |
| code_o | output | CODE_W (3) | Latched count, b2..b0, for the current DAC |
| done_o | output | 1 | Result valid, held until the next start |
| ovf_o | output | 1 | Count saturated during the last measurement |

## Verification
The bench models the load as a comparator level that stays high for H edges after the switch closes. H is swept across 0 to 7 and 12. The zero case shows that the synchronizer's stale "below" level still yields one count. The even values reproduce the four reference codes. The odd values 1 and 3 isolate single DAC bits. Lengths 6, 7 and 12 separate the largest value that still fits from saturation. A run of length 2 after an overflowed run shows that the flag is cleared. A second start pulse in the middle of a length-5 run, checked against the expected code and end time, shows that the request was ignored.

// File: rtl/rc_tau_pkg.sv
package rc_tau_pkg;

  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_RUN  = 2'd1,
    MS_DONE = 2'd2
  } meas_state_e;

endpackage

// File: rtl/rc_tau_sync.sv
module rc_tau_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_n;

  generate
    if (STAGES == 1) begin : g_single
      always_comb pipe_n = d_i;
    end else begin : g_chain
      always_comb pipe_n = {pipe_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_LVL}};
    else        pipe_q <= pipe_n;
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/rc_tau_ctrl.sv
module rc_tau_ctrl
  import rc_tau_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic below_i,
  output logic run_o,
  output logic clear_o,
  output logic stop_o,
  output logic done_o
);

  meas_state_e state_q, state_n;

  always_comb begin
    state_n = state_q;
    clear_o = 1'b0;
    stop_o  = 1'b0;
    case (state_q)
      MS_IDLE, MS_DONE: begin
        if (start_i) begin
          state_n = MS_RUN;
          clear_o = 1'b1;
        end
      end
      MS_RUN: begin
        if (!below_i) begin
          state_n = MS_DONE;
          stop_o  = 1'b1;
        end
      end
      default: state_n = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MS_IDLE;
    else        state_q <= state_n;
  end

  assign run_o  = (state_q == MS_RUN);
  assign done_o = (state_q == MS_DONE);

  // R9
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && start_i && below_i) |=> (run_o && !done_o));

  // R4
  stop_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !below_i) |=> (done_o && !run_o));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o && start_i) |=> (run_o && !done_o));

endmodule

// File: rtl/rc_tau_count.sv
module rc_tau_count #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         inc_i,
  input  logic         load_i,
  output logic [W-1:0] code_o,
  output logic         ovf_o
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_n;
  logic         sat_q, sat_n;
  logic [W-1:0] code_q;
  logic         ovf_q;
  logic         cnt_en;

  assign cnt_en = clear_i | inc_i;

  always_comb begin
    cnt_n = cnt_q;
    sat_n = sat_q;
    if (clear_i) begin
      cnt_n = '0;
      sat_n = 1'b0;
    end else if (inc_i) begin
      if (cnt_q == CNT_MAX) sat_n = 1'b1;
      else                  cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sat_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
      sat_q <= sat_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      ovf_q  <= 1'b0;
    end else if (load_i) begin
      code_q <= cnt_q;
      ovf_q  <= sat_q;
    end
  end

  assign code_o = code_q;
  assign ovf_o  = ovf_q;

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(code_o) && $stable(ovf_o)));

  // R6
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clear_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX && sat_q));

  // R3
  increment_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clear_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/rc_tau_meter.sv
module rc_tau_meter #(
  parameter int CODE_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cmp_below_i,
  output logic              excite_en_o,
  output logic [CODE_W-1:0] code_o,
  output logic              done_o,
  output logic              ovf_o
);

  logic below_s;
  logic run;
  logic clear;
  logic stop;
  logic inc;

  rc_tau_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cmp_below_i),
    .q_o   (below_s)
  );

  rc_tau_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .below_i (below_s),
    .run_o   (run),
    .clear_o (clear),
    .stop_o  (stop),
    .done_o  (done_o)
  );

  assign inc = run & below_s;

  rc_tau_count #(.W(CODE_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (clear),
    .inc_i   (inc),
    .load_i  (stop),
    .code_o  (code_o),
    .ovf_o   (ovf_o)
  );

  assign excite_en_o = run;

  // R6
  ovf_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (code_o == {CODE_W{1'b1}}));

  // R11
  excite_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $fell(excite_en_o));

endmodule

// File: tb/test_rc_tau_meter.sv
module test_rc_tau_meter;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic       cmp_below_i;
  logic       excite_en_o;
  logic [2:0] code_o;
  logic       done_o;
  logic       ovf_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int prev_code = 0;
  int prev_ovf = 0;

  rc_tau_meter i_rc_tau_meter (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cmp_below_i (cmp_below_i),
    .excite_en_o (excite_en_o),
    .code_o      (code_o),
    .done_o      (done_o),
    .ovf_o       (ovf_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // One measurement: raw comparator high for hi edges from the start edge.
  task automatic run_meas(input int hi, input bit poke, input string req);
    int  exp_code;
    int  exp_ovf;
    int  c0;
    int  lat;
    bit  seen;
    exp_code = (hi + 1 > 7) ? 7 : hi + 1;
    exp_ovf  = (hi + 1 > 7) ? 1 : 0;
    @(negedge clk);
    start_i = 1'b1;
    if (hi == 0) cmp_below_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    c0 = cyc;
    chk(excite_en_o == 1'b1, "R2", "excite after start", excite_en_o, 1);
    chk(done_o == 1'b0, "R2", "done after start", done_o, 0);
    chk(code_o == prev_code, "R7", "code held in run", code_o, prev_code);
    chk(ovf_o == prev_ovf, "R7", "ovf held in run", ovf_o, prev_ovf);
    for (int k = 1; k < hi; k++) begin
      if (poke && k == 1) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (poke && k == 1)
        chk(excite_en_o && !done_o, "R9", "run kept after extra start", excite_en_o, 1);
    end
    if (hi > 0) cmp_below_i = 1'b0;
    seen = 1'b0;
    for (int w = 0; w < 40 && !seen; w++) begin
      if (done_o) seen = 1'b1;
      else @(negedge clk);
    end
    lat = cyc - c0;
    chk(seen, "R4", "done reached", seen, 1);
    chk(lat == hi + 2, "R4", "end latency", lat, hi + 2);
    chk(code_o == exp_code, req, "code", code_o, exp_code);
    chk(ovf_o == exp_ovf, "R6", "ovf", ovf_o, exp_ovf);
    chk(excite_en_o == 1'b0, "R11", "excite off when done", excite_en_o, 0);
    cmp_below_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(done_o == 1'b1, "R8", "done held", done_o, 1);
    chk(code_o == exp_code, "R8", "code held", code_o, exp_code);
    prev_code = exp_code;
    prev_ovf  = exp_ovf;
  endtask

  task automatic t_reset;
    chk(excite_en_o == 1'b0, "R1", "excite in reset", excite_en_o, 0);
    chk(done_o == 1'b0, "R1", "done in reset", done_o, 0);
    chk(code_o == 3'd0, "R1", "code in reset", code_o, 0);
    chk(ovf_o == 1'b0, "R1", "ovf in reset", ovf_o, 0);
  endtask

  task automatic t_reference;
    run_meas(0, 1'b0, "R5");
    run_meas(2, 1'b0, "R5");
    run_meas(4, 1'b0, "R5");
    run_meas(6, 1'b0, "R5");
  endtask

  task automatic t_bits;
    run_meas(1, 1'b0, "R3");
    chk(code_o[1] && !code_o[2] && !code_o[0], "R10", "weight-2 bit", code_o, 2);
    run_meas(3, 1'b0, "R3");
    chk(code_o[2] && !code_o[1] && !code_o[0], "R10", "weight-4 bit", code_o, 4);
  endtask

  task automatic t_saturate;
    run_meas(7, 1'b0, "R6");
    run_meas(12, 1'b0, "R6");
    run_meas(2, 1'b0, "R6");
  endtask

  task automatic t_ignore;
    run_meas(5, 1'b1, "R9");
  endtask

  initial begin
    rst_n       = 1'b0;
    start_i     = 1'b0;
    cmp_below_i = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_reference;
    t_bits;
    t_saturate;
    t_ignore;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog act=0 exp=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule